// File: doc/BRIEF.md
# Posted Write Buffer Controller

This block sits between a local-bus slave port and the sequencer that masters a remote bus. Each local access arrives with two attributes from the address window that decoded it: whether writes to that window may be posted, and whether the window's remote data path is only 16 bits wide. A write to a posting window is captured into a single-entry buffer and acknowledged at once. The stored write is then drained to the remote side as one or more remote beats. Reads, and writes to windows without posting, use the same beat machinery, but their local acknowledge is held back until the final remote beat has finished.

The buffer holds one transfer. That transfer is a byte, a halfword, a 32-bit word, or a line of four 32-bit words. A line is issued as consecutive word beats in ascending address order. On a 16-bit window, every word is split into two halfword beats, with the lower address first. A remote bus error on a posted write cannot be returned to the local master. Instead it sets a sticky pending bit, and that bit drives an interrupt when the interrupt is enabled. The failing address is not kept. Software clears the pending bit with a write-one-to-clear pulse.

Top module: `pwb_ctrl`

## Requirements
- R1: A write with `win_post`=1 is acknowledged (`loc_ack`=1) in the cycle after it is accepted, before any remote beat completes.
- R2: `loc_size` codes are 0=byte, 1=halfword, 2=word, 3=line. A byte, halfword or word on a 32-bit window is one remote beat at `loc_addr` with `rq_size` equal to `loc_size` and `rq_wdata` = `loc_wdata[31:0]`.
- R3: A line is issued as four word beats (`rq_size`=2) at addresses base, base+4, base+8 and base+12. Beat k carries `loc_wdata[32k+31:32k]`.
- R4: A read, or a write with `win_post`=0, is acknowledged only after its last remote beat completes. Read data is returned in `loc_rdata`, with word k of a line at bits `[32k+31:32k]`.
- R5: With `win_d16`=1, each word (a single word or each word of a line) becomes two halfword beats (`rq_size`=1). The lower half goes first, at address a, carrying bits [15:0] in `rq_wdata[15:0]`. The upper half follows at a+2. On reads, `rq_rdata[15:0]` of each half is placed in the matching half of the word. Bytes and halfwords are not split.
- R6: While a transfer is in the buffer, a new local access of any kind is neither accepted nor acknowledged. It starts only after the last beat of the pending transfer.
- R7: A bus error (`rq_berr` with `rq_done`) on a posted write sets `irq_pend`. The output `irq` equals `irq_pend` AND `irq_en`.
- R8: An `irq_clr` pulse clears `irq_pend`. If a new posted error arrives in the same cycle, the pending bit stays set.
- R9: A bus error on a read or non-posted write is returned as `loc_berr`=1 together with `loc_ack`, and it leaves `irq_pend` unchanged.
- R10: A bus error ends the transfer. No further beats of that transfer are issued.
- R11: After reset, `loc_ack`, `loc_berr`, `rq_valid`, `irq_pend` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local access request, held until `loc_ack` |
| loc_we | input | 1 | 1 = write, 0 = read |
| loc_size | input | 2 | Transfer size code (R2) |
| loc_addr | input | AW | Local byte address |
| loc_wdata | input | 32*LINE_WORDS | Write data, word k in bits [32k+31:32k] |
| win_post | input | 1 | Decoded window allows posting |
| win_d16 | input | 1 | Decoded window has a 16-bit remote data path |
| loc_ack | output | 1 | One-cycle local acknowledge |
| loc_berr | output | 1 | Bus error on a non-posted access, valid with `loc_ack` |
| loc_rdata | output | 32*LINE_WORDS | Read data, valid with `loc_ack` |
| rq_valid | output | 1 | Remote beat requested; held with stable fields until `rq_done` |
| rq_we | output | 1 | Remote beat direction |
| rq_addr | output | AW | Remote beat byte address |
| rq_size | output | 2 | Remote beat size code |
| rq_wdata | output | 32 | Remote beat write data |
| rq_rdata | input | 32 | Remote beat read data, valid with `rq_done` |
| rq_done | input | 1 | Remote beat finished |
| rq_berr | input | 1 | Remote beat ended in a bus error, valid with `rq_done` |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the pending bit |
| irq_pend | output | 1 | Sticky posted-error pending bit |
| irq | output | 1 | Interrupt request |

## Verification
Two events can meet in one cycle: the bus error that ends a posted write setting the pending bit, and a software clear of that bit. The bench provokes this by letting its remote model raise `irq_clr` in the same cycle it returns the failing `rq_done`. It then requires `irq_pend` to be 1 afterwards, and it confirms that an isolated clear leaves the bit at 0. A second overlap is a new local request arriving while a posted write is still draining. The bench judges that case from the order of the logged remote beats and from when the acknowledge arrives.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;
endpackage

// File: rtl/pwb_beat.sv
module pwb_beat
    import pwb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_WORDS = 4,
    parameter int BCW        = 4
) (
    input  logic [AW-1:0]            base_i,
    input  logic [32*LINE_WORDS-1:0] data_i,
    input  xfer_size_e               size_i,
    input  logic                     line_i,
    input  logic                     split_i,
    input  logic [BCW-1:0]           beat_i,
    input  logic [31:0]              rdata_i,
    output logic [AW-1:0]            addr_o,
    output logic [1:0]               size_o,
    output logic [31:0]              wdata_o,
    output logic [32*LINE_WORDS-1:0] merged_o
);
    localparam int WIW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

    logic [BCW-1:0] wfull;
    logic [WIW-1:0] widx;
    logic           hsel;
    logic [31:0]    word;

    always_comb begin
        wfull   = split_i ? (beat_i >> 1) : beat_i;
        widx    = line_i ? wfull[WIW-1:0] : '0;
        hsel    = split_i & beat_i[0];
        word    = data_i[32*widx +: 32];
        addr_o  = base_i + AW'({widx, 2'b00}) + AW'({hsel, 1'b0});
        if (split_i)
            size_o = 2'(SZ_HALF);
        else if (line_i)
            size_o = 2'(SZ_WORD);
        else
            size_o = 2'(size_i);
        if (split_i)
            wdata_o = {16'h0000, hsel ? word[31:16] : word[15:0]};
        else
            wdata_o = word;
        merged_o = data_i;
        if (split_i)
            merged_o[32*widx + 16*hsel +: 16] = rdata_i[15:0];
        else
            merged_o[32*widx +: 32] = rdata_i;
    end
endmodule

// File: rtl/pwb_irq.sv
module pwb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic pend_o,
    output logic irq_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & en_i;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loc_req,
    input  logic                     loc_we,
    input  logic [1:0]               loc_size,
    input  logic [AW-1:0]            loc_addr,
    input  logic [32*LINE_WORDS-1:0] loc_wdata,
    input  logic                     win_post,
    input  logic                     win_d16,
    output logic                     loc_ack,
    output logic                     loc_berr,
    output logic [32*LINE_WORDS-1:0] loc_rdata,
    output logic                     rq_valid,
    output logic                     rq_we,
    output logic [AW-1:0]            rq_addr,
    output logic [1:0]               rq_size,
    output logic [31:0]              rq_wdata,
    input  logic [31:0]              rq_rdata,
    input  logic                     rq_done,
    input  logic                     rq_berr,
    input  logic                     irq_en,
    input  logic                     irq_clr,
    output logic                     irq_pend,
    output logic                     irq
);
    localparam int DW  = 32 * LINE_WORDS;
    localparam int BCW = $clog2(2 * LINE_WORDS) + 1;

    typedef struct packed {
        logic            busy;
        logic            posted;
        logic            we;
        logic            line;
        logic            split;
        xfer_size_e      size;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [BCW-1:0]  beat;
        logic [BCW-1:0]  last;
        logic            ack;
        logic            berr;
    } state_t;

    state_t      st_d, st_q;
    logic        accept;
    logic        irq_set;
    logic [DW-1:0] merged;
    xfer_size_e  req_size;
    logic        req_line, req_split;

    pwb_beat #(.AW(AW), .LINE_WORDS(LINE_WORDS), .BCW(BCW)) u_beat (
        .base_i  (st_q.addr),
        .data_i  (st_q.data),
        .size_i  (st_q.size),
        .line_i  (st_q.line),
        .split_i (st_q.split),
        .beat_i  (st_q.beat),
        .rdata_i (rq_rdata),
        .addr_o  (rq_addr),
        .size_o  (rq_size),
        .wdata_o (rq_wdata),
        .merged_o(merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        req_size  = xfer_size_e'(loc_size);
        req_line  = (req_size == SZ_LINE);
        req_split = win_d16 && (req_size == SZ_WORD || req_size == SZ_LINE);
        accept    = !st_q.busy && loc_req && !st_q.ack;
        irq_set   = 1'b0;
        if (accept) begin
            st_d.busy   = 1'b1;
            st_d.posted = loc_we & win_post;
            st_d.we     = loc_we;
            st_d.size   = req_size;
            st_d.line   = req_line;
            st_d.split  = req_split;
            st_d.addr   = loc_addr;
            st_d.data   = loc_we ? loc_wdata : '0;
            st_d.beat   = '0;
            if (req_line && req_split) st_d.last = BCW'(2 * LINE_WORDS - 1);
            else if (req_line)         st_d.last = BCW'(LINE_WORDS - 1);
            else if (req_split)        st_d.last = BCW'(1);
            else                       st_d.last = '0;
            st_d.ack    = loc_we & win_post;
            st_d.berr   = 1'b0;
        end else if (st_q.busy && rq_done) begin
            if (!st_q.we) st_d.data = merged;
            irq_set = rq_berr & st_q.posted;
            if (rq_berr || st_q.beat == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.ack  = !st_q.posted;
                st_d.berr = rq_berr & !st_q.posted;
            end else begin
                st_d.beat = st_q.beat + BCW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loc_ack   = st_q.ack;
    assign loc_berr  = st_q.ack & st_q.berr;
    assign loc_rdata = st_q.data;
    assign rq_valid  = st_q.busy;
    assign rq_we     = st_q.we;

    pwb_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (irq_clr),
        .en_i  (irq_en),
        .pend_o(irq_pend),
        .irq_o (irq)
    );

    a_r4_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rq_done) |=> rq_valid && $stable(rq_addr) && $stable(rq_wdata));
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rq_done && !rq_berr && st_q.beat != st_q.last) |=> rq_addr > $past(rq_addr));
    a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |=> !loc_ack);
    a_r9_berr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        loc_berr |-> loc_ack);
    a_r1_posted_early: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ack && rq_valid) |-> rq_we);
endmodule

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb;
    localparam int AW = 32;
    localparam int LW = 4;
    localparam int DW = 32 * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          loc_req = 0, loc_we = 0, win_post = 0, win_d16 = 0;
    logic [1:0]    loc_size = 0;
    logic [AW-1:0] loc_addr = 0;
    logic [DW-1:0] loc_wdata = 0;
    logic          loc_ack, loc_berr, rq_valid, rq_we;
    logic [DW-1:0] loc_rdata;
    logic [AW-1:0] rq_addr;
    logic [1:0]    rq_size;
    logic [31:0]   rq_wdata, rq_rdata;
    logic          rq_done = 0, rq_berr = 0;
    logic          irq_en = 0, clr_tb = 0, clr_sync = 0, irq_clr, irq_pend, irq;

    assign rq_rdata = {~rq_addr[15:0], rq_addr[15:0]};
    assign irq_clr  = clr_tb | (clr_sync & rq_done & rq_berr);

    pwb_ctrl #(.AW(AW), .LINE_WORDS(LW)) u_dut (.*);

    int errors = 0, checks = 0, cyc = 0;
    int lat = 0, err_beat = -1, wcnt = 0, nlog = 0;
    logic [31:0] log_addr [16];
    logic [1:0]  log_size [16];
    logic [31:0] log_wd   [16];

    always @(negedge clk) begin
        rq_done = 0;
        rq_berr = 0;
        if (!rst_n || !rq_valid) wcnt = lat;
        else if (wcnt == 0) begin
            rq_done = 1;
            rq_berr = (nlog == err_beat);
            if (nlog < 16) begin
                log_addr[nlog] = rq_addr;
                log_size[nlog] = rq_size;
                log_wd[nlog]   = rq_wdata;
            end
            nlog++;
            wcnt = lat;
        end else wcnt--;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int          a_cycles, a_beats;
    logic [DW-1:0] a_rdata;
    logic        a_berr;

    task automatic access(input bit we, input int sz, input logic [31:0] addr,
                          input logic [DW-1:0] wd, input bit post, input bit d16, input bit clear);
        @(negedge clk);
        if (clear) nlog = 0;
        loc_req = 1; loc_we = we; loc_size = 2'(sz); loc_addr = addr;
        loc_wdata = wd; win_post = post; win_d16 = d16;
        a_cycles = 0;
        do begin
            @(negedge clk);
            a_cycles++;
        end while (!loc_ack && a_cycles < 500);
        a_beats = nlog; a_rdata = loc_rdata; a_berr = loc_berr;
        loc_req = 0;
    endtask

    task automatic drain();
        int n = 0;
        while (rq_valid && n < 500) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!loc_ack && !loc_berr && !rq_valid && !irq_pend && !irq, "R11 reset",
            {loc_ack, loc_berr, rq_valid, irq_pend, irq}, 0);
        rst_n = 1;

        // sweep: sizes x window width x (posted write, plain write, read)
        for (int sz = 0; sz < 4; sz++) begin
            for (int d16 = 0; d16 < 2; d16++) begin
                for (int mode = 0; mode < 3; mode++) begin
                    automatic bit we = (mode != 2);
                    automatic bit post = (mode == 0);
                    automatic logic [31:0] base = 32'h1000_0000 + 32'((sz * 6 + d16 * 3 + mode) * 32'h40);
                    automatic logic [DW-1:0] wd;
                    automatic bit split = d16 && sz >= 2;
                    automatic bit line = (sz == 3);
                    automatic int nb = (line ? 4 : 1) * (split ? 2 : 1);
                    automatic bit ok = 1;
                    automatic logic [DW-1:0] exp_rd = '0;
                    for (int i = 0; i < LW; i++) wd[32*i +: 32] = 32'hA500_0000 + 32'(sz * 256 + d16 * 16 + mode * 4 + i) * 32'h0101;
                    lat = (sz + mode) % 3;
                    access(we, sz, base, wd, post, d16, 1);
                    if (post)
                        chk(a_cycles == 1 && a_beats == 0, "R1 posted ack early", a_cycles * 256 + a_beats, 256);
                    else
                        chk(a_beats == nb, "R4 ack after last beat", a_beats, nb);
                    drain();
                    chk(nlog == nb, line ? "R3 line beat count" : (split ? "R5 split beat count" : "R2 beat count"), nlog, nb);
                    for (int k = 0; k < nb; k++) begin
                        automatic int w = split ? k / 2 : k;
                        automatic int h = split ? k % 2 : 0;
                        automatic logic [31:0] ea = base + 32'(4 * w + 2 * h);
                        automatic logic [1:0]  es = split ? 2'd1 : (line ? 2'd2 : 2'(sz));
                        automatic logic [31:0] word = wd[32*w +: 32];
                        automatic logic [31:0] ew = split ? {16'h0, h ? word[31:16] : word[15:0]} : word;
                        automatic logic [31:0] rv = {~ea[15:0], ea[15:0]};
                        if (log_addr[k] != ea || log_size[k] != es || (we && log_wd[k] != ew)) ok = 0;
                        if (split) exp_rd[32*w + 16*h +: 16] = rv[15:0];
                        else       exp_rd[32*w +: 32] = rv;
                    end
                    chk(ok, line ? "R3 line beats ascending" : (split ? "R5 halfword beats" : "R2 beat fields"),
                        {log_addr[0], log_wd[0]}, {base, wd[31:0]});
                    if (!we)
                        chk(a_rdata == exp_rd, split ? "R5 read halves merged" : "R4 read data", a_rdata, exp_rd);
                end
            end
        end

        // R6: second access stalls behind a draining posted line
        lat = 3;
        access(1, 3, 32'h2000_0000, {32'h4, 32'h3, 32'h2, 32'h1}, 1, 0, 1);
        access(0, 2, 32'h3000_0100, '0, 0, 0, 0);
        chk(a_beats == 5 && log_addr[3] == 32'h2000_000C && log_addr[4] == 32'h3000_0100,
            "R6 stall until drained", {a_beats, log_addr[3], log_addr[4]}, {32'd5, 32'h2000_000C, 32'h3000_0100});
        drain();

        // R7 + R10: posted line error at beat 1, interrupt enabled
        lat = 0; irq_en = 1; err_beat = 1;
        access(1, 3, 32'h2100_0000, '1, 1, 0, 1);
        drain();
        chk(nlog == 2, "R10 error aborts beats", nlog, 2);
        chk(irq_pend && irq, "R7 posted error raises irq", {irq_pend, irq}, 2'b11);
        @(negedge clk); clr_tb = 1; @(negedge clk); clr_tb = 0; @(negedge clk);
        chk(!irq_pend && !irq, "R8 clear pending", {irq_pend, irq}, 0);

        // R7: enable low -> pending set, irq low
        irq_en = 0; err_beat = 0;
        access(1, 2, 32'h2200_0000, 32'h1234_5678, 1, 0, 1);
        drain();
        chk(irq_pend && !irq, "R7 enable gates irq", {irq_pend, irq}, 2'b10);
        @(negedge clk); clr_tb = 1; @(negedge clk); clr_tb = 0; @(negedge clk);
        chk(!irq_pend, "R8 clear pending again", irq_pend, 0);

        // R8: error set and clear in the same cycle -> set wins
        irq_en = 1; clr_sync = 1; err_beat = 0;
        access(1, 1, 32'h2300_0002, 32'h0000_BEEF, 1, 1, 1);
        drain();
        clr_sync = 0;
        chk(irq_pend && irq, "R8 set wins over clear", {irq_pend, irq}, 2'b11);
        @(negedge clk); clr_tb = 1; @(negedge clk); clr_tb = 0; @(negedge clk);

        // R9: non-posted write error -> loc_berr, pending untouched
        err_beat = 1;
        access(1, 2, 32'h2400_0000, 32'hCAFE_F00D, 0, 1, 1);
        chk(a_berr == 1 && a_beats == 2, "R9 berr on ack", {a_berr, 8'(a_beats)}, {1'b1, 8'd2});
        drain();
        chk(!irq_pend, "R9 pending unchanged", irq_pend, 0);
        err_beat = 0;
        access(0, 0, 32'h2500_0001, '0, 1, 0, 1);
        chk(a_berr == 1 && !irq_pend, "R9 read berr", {a_berr, irq_pend}, 2'b10);
        err_beat = -1;
        access(0, 0, 32'h2500_0001, '0, 0, 0, 1);
        chk(a_berr == 0, "R9 berr clears on good access", a_berr, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule